// File: doc/BRIEF.md
# Per-Cycle Power Quality Accumulator

This block turns a stream of paired voltage and current samples into compact power quality figures. Both channels are signed two's-complement words taken at the same instant and qualified by one shared strobe. At the decimated rate of 12.8 kS/s a 50 Hz mains cycle is exactly 256 strobes. Over each such cycle the block accumulates the sum, the sum of squares and the cross product of the two channels. From those sums it derives the mean square, RMS and DC offset of each channel, the active power and the apparent power.

The RMS values come from a bit-serial integer square root that runs in the gap before the next cycle closes. The per-cycle figures of five consecutive cycles are then averaged into one report, so a report is produced every 1280 samples (100 ms at the nominal rate). The report is offered on a valid/ready output. A report that is still unread when the next one is complete is replaced by the newer one, and a sticky flag records the loss. Decimation from the raw converter rate, harmonic and fluctuation analysis, frequency tracking and transport to a processor are handled elsewhere.

Top module: `pq_cycle_accum`

## Requirements
- R1: A synchronous reset clears the sample counter, every accumulator, the five-cycle sums and the cycle counter. After reset, rpt_valid and rpt_overrun read 0, and the next report covers only samples taken after the reset.
- R2: A sample is taken only on a clock edge where smp_valid is 1. Values on smp_v and smp_i without the strobe have no effect on any report. A cycle closes on its 256th strobe (2^CYCLE_LOG2).
- R3: The per-cycle mean square of each channel is floor(sum of squares / 256). It is exact at full scale, including every sample at -8192, which gives a mean square of 2^26.
- R4: The per-cycle RMS of each channel is floor(sqrt(mean square)). It is formed one result bit per clock, and the report that closes with a cycle is loaded on the 15th rising edge after the edge that takes the cycle's final sample. That is well before the next cycle can close.
- R5: The per-cycle DC offset of each channel is the sum of its 256 samples shifted right arithmetically by 8, so the result rounds toward minus infinity.
- R6: The per-cycle active power is the signed sum of the voltage-current products shifted right arithmetically by 8.
- R7: The per-cycle apparent power is the product of that cycle's voltage RMS and current RMS.
- R8: Each report field is the sum of the five per-cycle values of that quantity divided by 5, truncated toward zero.
- R9: After reset or after an accepted report, rpt_valid stays 0 until five more cycles have completed. One report is then formed per five cycles (1280 samples, 100 ms at 12.8 kS/s).
- R10: Once rpt_valid is 1, it and all report fields hold until an edge with rpt_ready at 1 accepts the report. rpt_valid is 0 after that edge unless a new report loads on the same edge.
- R11: If a new report loads while the previous one is valid and not accepted on that edge, rpt_overrun becomes 1 and stays 1 until reset, and the newer report replaces the older. If the older report is accepted on the load edge, rpt_overrun does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe shared by both channels |
| smp_v | input | SAMPLE_W | Voltage sample, signed |
| smp_i | input | SAMPLE_W | Current sample, signed |
| rpt_ready | input | 1 | Consumer accepts the report on this edge |
| rpt_valid | output | 1 | A report is presented |
| rpt_v_ms | output | 2*SAMPLE_W-1 | Averaged voltage mean square |
| rpt_i_ms | output | 2*SAMPLE_W-1 | Averaged current mean square |
| rpt_v_rms | output | SAMPLE_W | Averaged voltage RMS |
| rpt_i_rms | output | SAMPLE_W | Averaged current RMS |
| rpt_v_dc | output | SAMPLE_W | Averaged voltage DC offset, signed |
| rpt_i_dc | output | SAMPLE_W | Averaged current DC offset, signed |
| rpt_p_act | output | 2*SAMPLE_W | Averaged active power, signed |
| rpt_s_app | output | 2*SAMPLE_W-1 | Averaged apparent power |
| rpt_overrun | output | 1 | Sticky: a report was overwritten unread |

## Verification
Loading a new report and accepting the pending one can fall on the same clock edge. On that edge the output register is written while the handshake is trying to clear it. The bench provokes this by leaving one report unread, then raising rpt_ready exactly on the load edge of the next one, which is 15 edges after the closing sample. The edge passes only if rpt_valid stays 1, the fields show the newer report and rpt_overrun stays 0. A second run keeps rpt_ready low over the same edge and expects the flag to set, with the newer report taking the place of the older.

// File: rtl/pq_pkg.sv
package pq_pkg;

   // Report field indices, shared by the averaging array and the output map
   localparam int FLD_V_MS  = 0;
   localparam int FLD_I_MS  = 1;
   localparam int FLD_V_RMS = 2;
   localparam int FLD_I_RMS = 3;
   localparam int FLD_V_DC  = 4;
   localparam int FLD_I_DC  = 5;
   localparam int FLD_P_ACT = 6;
   localparam int FLD_S_APP = 7;
   localparam int NFIELD    = 8;

   // ceil(2^k / d): reciprocal multiplier for exact constant division
   function automatic logic [63:0] pq_recip(input int k, input int d);
      return ((64'd1 << k) + 64'(d) - 64'd1) / 64'(d);
   endfunction

endpackage

// File: rtl/pq_isqrt.sv
module pq_isqrt #(
   parameter int RW = 28
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [RW-1:0]   op,
   output logic            busy,
   output logic            done,
   output logic [RW/2-1:0] root
);
   localparam int R   = RW / 2;
   localparam int CNW = $clog2(R + 1);

   generate
      if (RW % 2 != 0 || RW < 4) begin : g_bad_rw
         $error("pq_isqrt: RW must be even and at least 4");
      end
   endgenerate

   logic [RW-1:0]  x_q;
   logic [RW-1:0]  op_q;
   logic [R+1:0]   rem_q;
   logic [R+1:0]   rem_n;
   logic [R-1:0]   root_n;
   logic [CNW-1:0] cnt_q;
   logic [R+2:0]   rem_sh;
   logic [R+2:0]   trial;

   always_comb begin
      rem_sh = {rem_q[R:0], x_q[RW-1:RW-2]};
      trial  = {1'b0, root, 2'b01};
      if (rem_sh >= trial) begin
         rem_n  = (R+2)'(rem_sh - trial);
         root_n = {root[R-2:0], 1'b1};
      end else begin
         rem_n  = (R+2)'(rem_sh);
         root_n = {root[R-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q   <= '0;
         op_q  <= '0;
         rem_q <= '0;
         root  <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            x_q   <= op;
            op_q  <= op;
            rem_q <= '0;
            root  <= '0;
            cnt_q <= CNW'(R);
            busy  <= 1'b1;
         end else if (busy) begin
            x_q   <= x_q << 2;
            rem_q <= rem_n;
            root  <= root_n;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R4: the finished root is the integer square root of the latched operand
   logic [RW+1:0] sq_lo;
   logic [RW+1:0] sq_hi;
   assign sq_lo = (RW+2)'(root) * (RW+2)'(root);
   assign sq_hi = ((RW+2)'(root) + 1'b1) * ((RW+2)'(root) + 1'b1);

   a_r4_root_exact: assert property (@(posedge clk) disable iff (rst)
      done |-> (sq_lo <= (RW+2)'(op_q)) && (sq_hi > (RW+2)'(op_q)));

endmodule

// File: rtl/pq_div_const.sv
module pq_div_const #(
   parameter int W   = 32,
   parameter int DIV = 5
) (
   input  logic signed [W-1:0] x,
   output logic signed [W-1:0] q
);
   localparam int SH = (DIV > 1) ? $clog2(DIV) : 0;

   generate
      if (DIV < 1 || W + SH > 62) begin : g_bad_div
         $error("pq_div_const: DIV must be at least 1 and W+log2(DIV) at most 62");
      end
   endgenerate

   logic [W-1:0] mag;
   logic [W-1:0] qmag;

   assign mag = x[W-1] ? W'(-x) : W'(x);

   generate
      if (DIV == (1 << SH)) begin : g_pow2
         assign qmag = mag >> SH;
      end else begin : g_recip
         localparam int          K     = W + SH;
         localparam int          MW    = W + 1;
         localparam logic [63:0] MFULL = pq_pkg::pq_recip(K, DIV);
         logic [W+MW-1:0] prod;
         assign prod = mag * MFULL[MW-1:0];
         assign qmag = W'(prod >> K);
      end
   endgenerate

   assign q = x[W-1] ? -$signed(qmag) : $signed(qmag);

endmodule

// File: rtl/pq_cyc_acc.sv
module pq_cyc_acc #(
   parameter int W     = 14,
   parameter int LOG2N = 8,
   parameter int ACC_W = 37
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     stb,
   input  logic signed [W-1:0]      v,
   input  logic signed [W-1:0]      i,
   output logic                     last,
   output logic signed [W+LOG2N-1:0] tot_sv,
   output logic signed [W+LOG2N-1:0] tot_si,
   output logic signed [ACC_W-1:0]  tot_qv,
   output logic signed [ACC_W-1:0]  tot_qi,
   output logic signed [ACC_W-1:0]  tot_p
);
   localparam int SUM_W = W + LOG2N;

   generate
      if (ACC_W < 2 * W + LOG2N + 1) begin : g_bad_acc
         $error("pq_cyc_acc: ACC_W too narrow for a full cycle of products");
      end
   endgenerate

   logic [LOG2N-1:0]        cnt_q;
   logic signed [W-1:0]     smp [2];
   logic signed [SUM_W-1:0] stot [2];
   logic signed [ACC_W-1:0] qtot [2];

   assign last   = stb && (cnt_q == {LOG2N{1'b1}});
   assign smp[0] = v;
   assign smp[1] = i;

   always_ff @(posedge clk) begin
      if (rst)      cnt_q <= '0;
      else if (stb) cnt_q <= cnt_q + 1'b1;
   end

   for (genvar c = 0; c < 2; c++) begin : g_ch
      logic signed [2*W-1:0]   sq;
      logic signed [SUM_W-1:0] sacc_q;
      logic signed [ACC_W-1:0] qacc_q;

      assign sq      = smp[c] * smp[c];
      assign stot[c] = sacc_q + {{LOG2N{smp[c][W-1]}}, smp[c]};
      assign qtot[c] = qacc_q + {{(ACC_W-2*W){sq[2*W-1]}}, sq};

      always_ff @(posedge clk) begin
         if (rst) begin
            sacc_q <= '0;
            qacc_q <= '0;
         end else if (stb) begin
            sacc_q <= last ? '0 : stot[c];
            qacc_q <= last ? '0 : qtot[c];
         end
      end

      // R3: a running sum of squares never wraps into the sign bit
      a_r3_sq_acc_nonneg: assert property (@(posedge clk) disable iff (rst)
         !qacc_q[ACC_W-1]);
   end

   logic signed [2*W-1:0]   pv;
   logic signed [ACC_W-1:0] pacc_q;
   assign pv    = v * i;
   assign tot_p = pacc_q + {{(ACC_W-2*W){pv[2*W-1]}}, pv};

   always_ff @(posedge clk) begin
      if (rst)      pacc_q <= '0;
      else if (stb) pacc_q <= last ? '0 : tot_p;
   end

   assign tot_sv = stot[0];
   assign tot_si = stot[1];
   assign tot_qv = qtot[0];
   assign tot_qi = qtot[1];

   // R2: the sample counter moves only with the strobe
   a_r2_count_on_strobe: assert property (@(posedge clk) disable iff (rst)
      !stb |=> $stable(cnt_q));

endmodule

// File: rtl/pq_cycle_accum.sv
module pq_cycle_accum #(
   parameter int SAMPLE_W          = 14,
   parameter int CYCLE_LOG2        = 8,
   parameter int CYCLES_PER_REPORT = 5
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           smp_valid,
   input  logic signed [SAMPLE_W-1:0]     smp_v,
   input  logic signed [SAMPLE_W-1:0]     smp_i,
   input  logic                           rpt_ready,
   output logic                           rpt_valid,
   output logic [2*SAMPLE_W-2:0]          rpt_v_ms,
   output logic [2*SAMPLE_W-2:0]          rpt_i_ms,
   output logic [SAMPLE_W-1:0]            rpt_v_rms,
   output logic [SAMPLE_W-1:0]            rpt_i_rms,
   output logic signed [SAMPLE_W-1:0]     rpt_v_dc,
   output logic signed [SAMPLE_W-1:0]     rpt_i_dc,
   output logic signed [2*SAMPLE_W-1:0]   rpt_p_act,
   output logic [2*SAMPLE_W-2:0]          rpt_s_app,
   output logic                           rpt_overrun
);
   import pq_pkg::*;

   localparam int ACC_W = 2 * SAMPLE_W + CYCLE_LOG2 + 1;
   localparam int SUM_W = SAMPLE_W + CYCLE_LOG2;
   localparam int MS_W  = 2 * SAMPLE_W - 1;
   localparam int RAD_W = 2 * SAMPLE_W;
   localparam int EXT_W = (CYCLES_PER_REPORT > 1) ? $clog2(CYCLES_PER_REPORT) : 1;
   localparam int FS_W  = 2 * SAMPLE_W + EXT_W + 1;
   localparam int CC_W  = EXT_W;

   generate
      if (SAMPLE_W < 4 || SAMPLE_W > 24) begin : g_bad_w
         $error("pq_cycle_accum: SAMPLE_W out of range 4..24");
      end
      if ((1 << CYCLE_LOG2) <= SAMPLE_W + 2) begin : g_bad_len
         $error("pq_cycle_accum: cycle too short for the serial square root");
      end
      if (CYCLES_PER_REPORT < 1) begin : g_bad_cyc
         $error("pq_cycle_accum: CYCLES_PER_REPORT must be at least 1");
      end
   endgenerate

   // ---------------- per-cycle sums ----------------
   logic                    acc_last;
   logic signed [SUM_W-1:0] tot_sv, tot_si;
   logic signed [ACC_W-1:0] tot_qv, tot_qi, tot_p;

   pq_cyc_acc #(.W(SAMPLE_W), .LOG2N(CYCLE_LOG2), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .stb(smp_valid), .v(smp_v), .i(smp_i),
      .last(acc_last), .tot_sv(tot_sv), .tot_si(tot_si),
      .tot_qv(tot_qv), .tot_qi(tot_qi), .tot_p(tot_p));

   // ---------------- cycle means ----------------
   logic signed [ACC_W-1:0] qsh [2];
   logic signed [SUM_W-1:0] ssh [2];
   logic signed [ACC_W-1:0] psh;
   logic [MS_W-1:0]          ms_n [2];
   logic signed [SAMPLE_W-1:0] dc_n [2];

   always_comb begin
      qsh[0] = tot_qv >>> CYCLE_LOG2;
      qsh[1] = tot_qi >>> CYCLE_LOG2;
      ssh[0] = tot_sv >>> CYCLE_LOG2;
      ssh[1] = tot_si >>> CYCLE_LOG2;
      psh    = tot_p  >>> CYCLE_LOG2;
      for (int c = 0; c < 2; c++) begin
         ms_n[c] = qsh[c][MS_W-1:0];
         dc_n[c] = ssh[c][SAMPLE_W-1:0];
      end
   end

   logic [MS_W-1:0]              ms_q [2];
   logic signed [SAMPLE_W-1:0]   dc_q [2];
   logic signed [2*SAMPLE_W-1:0] p_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int c = 0; c < 2; c++) begin
            ms_q[c] <= '0;
            dc_q[c] <= '0;
         end
         p_q <= '0;
      end else if (acc_last) begin
         for (int c = 0; c < 2; c++) begin
            ms_q[c] <= ms_n[c];
            dc_q[c] <= dc_n[c];
         end
         p_q <= psh[2*SAMPLE_W-1:0];
      end
   end

   // ---------------- RMS, one bit per clock ----------------
   logic                sq_busy [2];
   logic                sq_done [2];
   logic [SAMPLE_W-1:0] rms     [2];

   for (genvar c = 0; c < 2; c++) begin : g_rms
      pq_isqrt #(.RW(RAD_W)) u_sqrt (
         .clk(clk), .rst(rst), .start(acc_last),
         .op(RAD_W'(ms_n[c])), .busy(sq_busy[c]), .done(sq_done[c]),
         .root(rms[c]));
   end

   logic                  cyc_ready;
   logic [2*SAMPLE_W-1:0] s_prod;
   assign cyc_ready = sq_done[0];
   assign s_prod    = rms[0] * rms[1];

   // ---------------- five-cycle averaging ----------------
   logic signed [FS_W-1:0] fnew  [NFIELD];
   logic signed [FS_W-1:0] fsum_q[NFIELD];
   logic signed [FS_W-1:0] ftot  [NFIELD];
   logic signed [FS_W-1:0] favg  [NFIELD];
   logic signed [FS_W-1:0] rpt_q [NFIELD];
   logic [CC_W-1:0]        ccount_q;
   logic                   load;

   always_comb begin
      fnew[FLD_V_MS]  = FS_W'(ms_q[0]);
      fnew[FLD_I_MS]  = FS_W'(ms_q[1]);
      fnew[FLD_V_RMS] = FS_W'(rms[0]);
      fnew[FLD_I_RMS] = FS_W'(rms[1]);
      fnew[FLD_V_DC]  = FS_W'(dc_q[0]);
      fnew[FLD_I_DC]  = FS_W'(dc_q[1]);
      fnew[FLD_P_ACT] = FS_W'(p_q);
      fnew[FLD_S_APP] = FS_W'(s_prod);
   end

   for (genvar f = 0; f < NFIELD; f++) begin : g_fld
      assign ftot[f] = fsum_q[f] + fnew[f];
      pq_div_const #(.W(FS_W), .DIV(CYCLES_PER_REPORT)) u_div (
         .x(ftot[f]), .q(favg[f]));
   end

   assign load = cyc_ready && (ccount_q == CC_W'(CYCLES_PER_REPORT - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int f = 0; f < NFIELD; f++) begin
            fsum_q[f] <= '0;
            rpt_q[f]  <= '0;
         end
         ccount_q    <= '0;
         rpt_valid   <= 1'b0;
         rpt_overrun <= 1'b0;
      end else begin
         if (load) begin
            for (int f = 0; f < NFIELD; f++) begin
               fsum_q[f] <= '0;
               rpt_q[f]  <= favg[f];
            end
            ccount_q  <= '0;
            rpt_valid <= 1'b1;
            if (rpt_valid && !rpt_ready) rpt_overrun <= 1'b1;
         end else begin
            if (cyc_ready) begin
               for (int f = 0; f < NFIELD; f++) fsum_q[f] <= ftot[f];
               ccount_q <= ccount_q + 1'b1;
            end
            if (rpt_valid && rpt_ready) rpt_valid <= 1'b0;
         end
      end
   end

   assign rpt_v_ms  = rpt_q[FLD_V_MS][MS_W-1:0];
   assign rpt_i_ms  = rpt_q[FLD_I_MS][MS_W-1:0];
   assign rpt_v_rms = rpt_q[FLD_V_RMS][SAMPLE_W-1:0];
   assign rpt_i_rms = rpt_q[FLD_I_RMS][SAMPLE_W-1:0];
   assign rpt_v_dc  = rpt_q[FLD_V_DC][SAMPLE_W-1:0];
   assign rpt_i_dc  = rpt_q[FLD_I_DC][SAMPLE_W-1:0];
   assign rpt_p_act = rpt_q[FLD_P_ACT][2*SAMPLE_W-1:0];
   assign rpt_s_app = rpt_q[FLD_S_APP][MS_W-1:0];

   // ---------------- assertions ----------------
   // R1: first cycle out of reset shows an empty, clean output
   a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !rpt_valid && !rpt_overrun);

   // R4: both square roots are idle again when the next cycle closes
   a_r4_root_before_boundary: assert property (@(posedge clk) disable iff (rst)
      acc_last |-> !sq_busy[0] && !sq_busy[1] && !sq_done[0]);

   // R9: a report appears only on the edge after a cycle result completes
   a_r9_valid_after_cycle: assert property (@(posedge clk) disable iff (rst)
      $rose(rpt_valid) |-> $past(sq_done[0]));

   // R10: an unaccepted report stays valid and unchanged unless replaced
   a_r10_hold_valid: assert property (@(posedge clk) disable iff (rst)
      rpt_valid && !rpt_ready |=> rpt_valid);

   a_r10_fields_stable: assert property (@(posedge clk) disable iff (rst)
      rpt_valid && !rpt_ready && !load |=>
         $stable(rpt_v_rms) && $stable(rpt_i_rms) && $stable(rpt_p_act) && $stable(rpt_v_dc));

   // R11: overrun is sticky and only rises after a report sat unaccepted
   a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
      rpt_overrun |=> rpt_overrun);

   a_r11_overrun_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(rpt_overrun) |-> $past(rpt_valid && !rpt_ready) && rpt_valid);

endmodule

// File: tb/tb_pq_cycle_accum.sv
module tb_pq_cycle_accum;
   localparam int W = 14;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                  rst, stb, rdy;
   logic signed [W-1:0]   sv, si;
   logic                  rpt_valid, rpt_overrun;
   logic [2*W-2:0]        v_ms, i_ms, s_app;
   logic [W-1:0]          v_rms, i_rms;
   logic signed [W-1:0]   v_dc, i_dc;
   logic signed [2*W-1:0] p_act;

   pq_cycle_accum dut (
      .clk(clk), .rst(rst), .smp_valid(stb), .smp_v(sv), .smp_i(si),
      .rpt_ready(rdy), .rpt_valid(rpt_valid),
      .rpt_v_ms(v_ms), .rpt_i_ms(i_ms), .rpt_v_rms(v_rms), .rpt_i_rms(i_rms),
      .rpt_v_dc(v_dc), .rpt_i_dc(i_dc), .rpt_p_act(p_act), .rpt_s_app(s_app),
      .rpt_overrun(rpt_overrun));

   // Stimulus table: v_even, v_odd, i_pairA, i_pairB, per-cycle voltage step
   localparam int NROW = 4;
   localparam int TBL [NROW][5] = '{
      '{ 1000, -1000,   500,  -500,  0},
      '{ 3000,  1000,  -200,   800, 37},
      '{-8192, -8192, -8192, -8192,  0},
      '{    6,    -5,     3,    -4, -2}};

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     finished = 1'b0;
   longint exp_f [8];
   string  fname [8] = '{"v_ms", "i_ms", "v_rms", "i_rms", "v_dc", "i_dc", "p_act", "s_app"};

   task automatic chk(input string req, input string what, input longint act, input longint expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic longint isq(input longint x);
      longint r = longint'($floor($sqrt(real'(x))));
      while (r * r > x) r--;
      while ((r + 1) * (r + 1) <= x) r++;
      return r;
   endfunction

   function automatic longint port_val(input int f);
      case (f)
         0: return longint'(v_ms);
         1: return longint'(i_ms);
         2: return longint'(v_rms);
         3: return longint'(i_rms);
         4: return longint'(v_dc);
         5: return longint'(i_dc);
         6: return longint'(p_act);
         default: return longint'(s_app);
      endcase
   endfunction

   task automatic check_fields(input string tag);
      for (int f = 0; f < 8; f++) begin
         string req;
         case (f)
            0, 1: req = "R3 R8";
            2, 3: req = "R4 R8";
            4, 5: req = "R5 R8";
            6:    req = "R6 R8";
            default: req = "R7 R8";
         endcase
         chk(req, {tag, " ", fname[f]}, port_val(f), exp_f[f]);
      end
   endtask

   // Feeds five cycles of row r; builds expected report; waits to edge 16.
   // collide=1 raises rpt_ready for the load edge only.
   task automatic feed_report(input int r, input bit collide,
                              output bit early, output bit val15, output bit val16);
      longint fs [8];
      early = 1'b0;
      for (int f = 0; f < 8; f++) fs[f] = 0;
      for (int c = 0; c < 5; c++) begin
         longint s_v = 0, s_i = 0, q_v = 0, q_i = 0, pp = 0;
         longint rv, ri;
         for (int n = 0; n < 256; n++) begin
            int vv, ii;
            if (n % 7 == 3) begin
               @(negedge clk);
               stb = 1'b0; sv = 14'sh1FFF; si = -14'sh2000;  // ignored junk, R2
               if (rpt_valid && !collide) early = 1'b1;
            end
            vv = ((n % 2) == 0 ? TBL[r][0] : TBL[r][1]) + c * TBL[r][4];
            ii = (((n / 2) % 2) == 0) ? TBL[r][2] : TBL[r][3];
            @(negedge clk);
            if (rpt_valid && !collide) early = 1'b1;
            stb = 1'b1; sv = W'(vv); si = W'(ii);
            s_v += vv; s_i += ii; q_v += vv * vv; q_i += ii * ii; pp += vv * ii;
         end
         rv = isq(q_v / 256);
         ri = isq(q_i / 256);
         fs[0] += q_v / 256;   fs[1] += q_i / 256;
         fs[2] += rv;          fs[3] += ri;
         fs[4] += s_v >>> 8;   fs[5] += s_i >>> 8;
         fs[6] += pp >>> 8;    fs[7] += rv * ri;
      end
      for (int f = 0; f < 8; f++) exp_f[f] = fs[f] / 5;
      for (int k = 1; k <= 15; k++) begin
         @(negedge clk);
         stb = 1'b0; sv = 14'sh0155; si = -14'sh0AAA;
      end
      val15 = rpt_valid;
      if (collide) rdy = 1'b1;
      @(negedge clk);
      val16 = rpt_valid;
      rdy = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit e, v15, v16;
      longint hold_rms;
      rst = 1'b1; stb = 1'b0; rdy = 1'b0; sv = '0; si = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "valid after reset", rpt_valid, 0);
      chk("R1", "overrun after reset", rpt_overrun, 0);

      // table-driven reports
      for (int r = 0; r < NROW; r++) begin
         string tag;
         tag = $sformatf("row%0d", r);
         feed_report(r, 1'b0, e, v15, v16);
         chk("R9", {tag, " valid before five cycles"}, e, 0);
         chk("R4", {tag, " valid at edge 15"}, v15, 0);
         chk("R4", {tag, " valid at edge 16"}, v16, 1);
         check_fields(tag);
         hold_rms = longint'(v_rms);
         repeat (3) @(negedge clk);
         chk("R10", {tag, " valid held"}, rpt_valid, 1);
         chk("R10", {tag, " rms held"}, longint'(v_rms), hold_rms);
         rdy = 1'b1;
         @(negedge clk);
         rdy = 1'b0;
         chk("R10", {tag, " valid cleared on accept"}, rpt_valid, 0);
      end
      chk("R11", "no overrun in normal flow", rpt_overrun, 0);

      // load and accept on the same edge
      feed_report(1, 1'b0, e, v15, v16);
      feed_report(0, 1'b1, e, v15, v16);
      chk("R11", "collide valid kept", v16, 1);
      chk("R11", "collide no overrun", rpt_overrun, 0);
      check_fields("collide");
      rdy = 1'b1; @(negedge clk); rdy = 1'b0;

      // overwrite while pending
      feed_report(3, 1'b0, e, v15, v16);
      feed_report(2, 1'b0, e, v15, v16);
      chk("R11", "overrun set", rpt_overrun, 1);
      chk("R11", "newer report valid", rpt_valid, 1);
      check_fields("overwrite");
      rdy = 1'b1; @(negedge clk); rdy = 1'b0;
      repeat (5) @(negedge clk);
      chk("R11", "overrun sticky", rpt_overrun, 1);
      chk("R10", "valid cleared after overwrite", rpt_valid, 0);

      // reset mid-cycle clears partial sums
      for (int n = 0; n < 100; n++) begin
         @(negedge clk); stb = 1'b1; sv = 14'sd3000; si = 14'sd800;
      end
      @(negedge clk); stb = 1'b0; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      @(negedge clk);
      chk("R1", "overrun cleared", rpt_overrun, 0);
      chk("R1", "valid cleared", rpt_valid, 0);
      feed_report(0, 1'b0, e, v15, v16);
      chk("R1", "report after mid-cycle reset valid", v16, 1);
      check_fields("R1 post-reset");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule